// File: doc/BRIEF.md
# Floppy Sector Search and Read Controller

This block sits behind the read channel of a floppy drive, after the bit decoder has turned the flux stream into bytes. Once the head is on the wanted track, software or a sequencer issues a command that names a track number and a sector number. The controller then watches the byte stream for address headers. It compares each ID field with the request and, on a hit, waits for the data field that follows. It passes the bytes of that field out one at a time.

The controller does not know the angular position of the disk and makes no assumption about sector order. It checks headers as they pass under the head. The index pulse is used only as a timeout clock. When the allowed number of disk revolutions has passed with no matching header, the command ends with a not-found error. Head stepping, bit decoding, clock recovery and CRC checking are handled elsewhere.

Top module: `sector_seek_ctrl`

## Requirements
- R1: A mark byte is recognised only when it directly follows three consecutive valid bytes equal to 0xA1 with `sync_flag` high. The mark byte itself has `sync_flag` low. 0xFE marks an ID field and 0xFB marks a data field. A run of only two sync bytes does not qualify.
- R2: The six bytes after an ID mark are, in order: track, head, sector, size code, and two CRC bytes. A header matches only when both the track byte and the sector byte equal the requested values. The head and CRC bytes are ignored. A header with a differing track is skipped like any other mismatch, and the search continues.
- R3: Headers are accepted in whatever order they arrive, with any sector number from 1 to 255. When two headers match, the first one seen is served. Once the command has completed, later headers and data fields produce no output.
- R4: After a matching ID, the bytes that follow the next data mark appear on `data_out` with `data_valid` high. Each appears one clock after it was presented on `byte_in`. Exactly 128 << N bytes are passed, where N is the low three bits of the size code. Data fields that belong to non-matching headers are never output.
- R5: `done` is a single-cycle pulse that is high in the same cycle as the last data byte.
- R6: While the command is searching, `not_found` pulses for one cycle once the number of index rising edges reaches the limit, and the command ends. The limit is 2 when `three_revs` was low at command time and 3 when it was high.
- R7: Only rising edges of `index_pulse` are counted. A pulse held high for several cycles counts once. The count is cleared by each accepted command, and edges seen while idle are ignored.
- R8: If no data mark arrives within 64 valid bytes after a matching ID field, the controller goes back to header search. A data mark that arrives later is then ignored.
- R9: `start` is accepted only while idle. The requested track and sector and `three_revs` are captured at that moment. A `start` while busy has no effect.
- R10: During and right after reset, `data_valid`, `done` and `not_found` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, taken only while idle |
| req_track | input | 8 | Requested track number |
| req_sector | input | 8 | Requested sector number |
| three_revs | input | 1 | 0: give up after 2 index edges, 1: after 3 |
| byte_valid | input | 1 | A decoded byte is present on byte_in this cycle |
| byte_in | input | 8 | Decoded byte from the read channel |
| sync_flag | input | 1 | The present byte was decoded as a sync pattern |
| index_pulse | input | 1 | Index sensor, once per revolution |
| data_valid | output | 1 | data_out carries a sector data byte |
| data_out | output | 8 | Sector data byte |
| done | output | 1 | One-cycle pulse with the last data byte |
| not_found | output | 1 | One-cycle pulse when the search times out |

## Verification
The bench hides the wanted sector behind headers with other sector numbers and a header with the wrong track. It also sends a duplicate header and a header preceded by only two sync bytes. A controller that compared only the sector, accepted a short sync run or served the second duplicate would put unexpected bytes into the scoreboard. The data-mark window is tested once inside and once beyond 64 bytes; a controller with no window would stream the late data field. The timeout is tested at two and at three revolutions, with index pulses sent while idle and an index pulse held high for many cycles. A controller that counted levels or did not clear the count would raise not-found early. A second start sent while busy checks that the captured request stays fixed.

// File: rtl/sector_seek_pkg.sv
package sector_seek_pkg;

    localparam int BYTE_W   = 8;
    localparam int SIZE_W   = 3;
    localparam int LEN_W    = 15;
    localparam int FLD_W    = 3;

    localparam logic [BYTE_W-1:0] SYNC_CODE = 8'hA1;
    localparam logic [BYTE_W-1:0] ID_CODE   = 8'hFE;
    localparam logic [BYTE_W-1:0] DATA_CODE = 8'hFB;

    // byte positions inside the ID field, counted after the mark
    localparam int POS_TRACK  = 0;
    localparam int POS_SECTOR = 2;
    localparam int POS_SIZE   = 3;
    localparam int POS_LAST   = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_IDFLD,
        ST_WAITDM,
        ST_XFER
    } seek_state_t;

    typedef struct packed {
        logic              trk_hit;
        logic              sec_hit;
        logic [SIZE_W-1:0] size;
    } id_info_t;

    function automatic logic [LEN_W-1:0] field_len(input logic [SIZE_W-1:0] n);
        return LEN_W'(128) << n;
    endfunction

endpackage

// File: rtl/mark_detect.sv
module mark_detect
    import sector_seek_pkg::*;
#(
    parameter int SYNC_RUN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              sync_flag,
    output logic              id_mark,
    output logic              data_mark
);
    localparam int RUN_W = $clog2(SYNC_RUN + 1);

    logic [RUN_W-1:0] run_q;
    logic             is_sync;
    logic             armed;

    assign is_sync = sync_flag && (byte_in == SYNC_CODE);
    assign armed   = byte_valid && !sync_flag && (run_q == RUN_W'(SYNC_RUN));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (byte_valid) begin
            if (!is_sync)
                run_q <= '0;
            else if (run_q != RUN_W'(SYNC_RUN))
                run_q <= run_q + 1'b1;
        end
    end

    assign id_mark   = armed && (byte_in == ID_CODE);
    assign data_mark = armed && (byte_in == DATA_CODE);
endmodule

// File: rtl/rev_counter.sv
module rev_counter #(
    parameter int REV_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             enable,
    input  logic             index_pulse,
    input  logic [REV_W-1:0] limit,
    output logic             expired
);
    logic             idx_q;
    logic [REV_W-1:0] revs_q;
    logic             rise;

    assign rise = index_pulse && !idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= 1'b0;
            revs_q <= '0;
        end else begin
            idx_q <= index_pulse;
            if (clear)
                revs_q <= '0;
            else if (enable && rise && (revs_q != '1))
                revs_q <= revs_q + 1'b1;
        end
    end

    assign expired = enable && (revs_q >= limit);
endmodule

// File: rtl/seek_fsm.sv
module seek_fsm
    import sector_seek_pkg::*;
#(
    parameter int DM_WINDOW = 64,
    parameter int REV_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BYTE_W-1:0] req_track,
    input  logic [BYTE_W-1:0] req_sector,
    input  logic              three_revs,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              id_mark,
    input  logic              data_mark,
    input  logic              expired,
    output logic              cmd_accept,
    output logic              searching,
    output logic [REV_W-1:0]  limit,
    output logic              data_valid,
    output logic [BYTE_W-1:0] data_out,
    output logic              done,
    output logic              not_found
);
    seek_state_t       state_q;
    logic [BYTE_W-1:0] trk_q, sec_q;
    id_info_t          info_q;
    logic [FLD_W-1:0]  fld_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [REV_W-1:0]  lim_q;

    assign cmd_accept = (state_q == ST_IDLE) && start;
    assign searching  = (state_q == ST_HUNT) || (state_q == ST_IDFLD) || (state_q == ST_WAITDM);
    assign limit      = lim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            trk_q      <= '0;
            sec_q      <= '0;
            info_q     <= '0;
            fld_q      <= '0;
            cnt_q      <= '0;
            lim_q      <= REV_W'(2);
            data_valid <= 1'b0;
            data_out   <= '0;
            done       <= 1'b0;
            not_found  <= 1'b0;
        end else begin
            data_valid <= 1'b0;
            done       <= 1'b0;
            not_found  <= 1'b0;
            if (searching && expired) begin
                not_found <= 1'b1;
                state_q   <= ST_IDLE;
            end else begin
                case (state_q)
                    ST_IDLE: if (start) begin
                        trk_q   <= req_track;
                        sec_q   <= req_sector;
                        lim_q   <= three_revs ? REV_W'(3) : REV_W'(2);
                        state_q <= ST_HUNT;
                    end
                    ST_HUNT: if (id_mark) begin
                        fld_q   <= '0;
                        state_q <= ST_IDFLD;
                    end
                    ST_IDFLD: if (byte_valid) begin
                        fld_q <= fld_q + 1'b1;
                        if (fld_q == FLD_W'(POS_TRACK))
                            info_q.trk_hit <= (byte_in == trk_q);
                        if (fld_q == FLD_W'(POS_SECTOR))
                            info_q.sec_hit <= (byte_in == sec_q);
                        if (fld_q == FLD_W'(POS_SIZE))
                            info_q.size <= byte_in[SIZE_W-1:0];
                        if (fld_q == FLD_W'(POS_LAST)) begin
                            cnt_q   <= '0;
                            state_q <= (info_q.trk_hit && info_q.sec_hit) ? ST_WAITDM : ST_HUNT;
                        end
                    end
                    ST_WAITDM: if (data_mark) begin
                        cnt_q   <= '0;
                        state_q <= ST_XFER;
                    end else if (byte_valid) begin
                        if (cnt_q == LEN_W'(DM_WINDOW - 1))
                            state_q <= ST_HUNT;
                        else
                            cnt_q <= cnt_q + 1'b1;
                    end
                    ST_XFER: if (byte_valid) begin
                        data_valid <= 1'b1;
                        data_out   <= byte_in;
                        if (cnt_q == field_len(info_q.size) - 1'b1) begin
                            done    <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sector_seek_ctrl.sv
module sector_seek_ctrl
    import sector_seek_pkg::*;
#(
    parameter int SYNC_RUN  = 3,
    parameter int DM_WINDOW = 64,
    parameter int REV_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        req_track,
    input  logic [7:0]        req_sector,
    input  logic              three_revs,
    input  logic              byte_valid,
    input  logic [7:0]        byte_in,
    input  logic              sync_flag,
    input  logic              index_pulse,
    output logic              data_valid,
    output logic [7:0]        data_out,
    output logic              done,
    output logic              not_found
);
    logic             id_mark, data_mark, expired, cmd_accept, searching;
    logic [REV_W-1:0] limit;

    mark_detect #(.SYNC_RUN(SYNC_RUN)) u_mark (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_in(byte_in),
        .sync_flag(sync_flag), .id_mark(id_mark), .data_mark(data_mark)
    );

    rev_counter #(.REV_W(REV_W)) u_revs (
        .clk(clk), .rst(rst), .clear(cmd_accept), .enable(searching),
        .index_pulse(index_pulse), .limit(limit), .expired(expired)
    );

    seek_fsm #(.DM_WINDOW(DM_WINDOW), .REV_W(REV_W)) u_fsm (
        .clk(clk), .rst(rst), .start(start), .req_track(req_track),
        .req_sector(req_sector), .three_revs(three_revs),
        .byte_valid(byte_valid), .byte_in(byte_in), .id_mark(id_mark),
        .data_mark(data_mark), .expired(expired), .cmd_accept(cmd_accept),
        .searching(searching), .limit(limit), .data_valid(data_valid),
        .data_out(data_out), .done(done), .not_found(not_found)
    );
endmodule

// File: rtl/sector_seek_chk.sv
module sector_seek_chk (
    input logic clk,
    input logic rst,
    input logic byte_valid,
    input logic data_valid,
    input logic done,
    input logic not_found
);
    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    // R5
    done_last_chk: assert property (@(posedge clk) disable iff (rst) done |-> data_valid);
    // R6
    nf_single_chk: assert property (@(posedge clk) disable iff (rst) not_found |=> !not_found);
    // R6
    nf_quiet_chk: assert property (@(posedge clk) disable iff (rst) not_found |-> !data_valid);
    // R4
    data_src_chk: assert property (@(posedge clk) disable iff (rst) data_valid |-> $past(byte_valid));
endmodule

bind sector_seek_ctrl sector_seek_chk u_chk (
    .clk(clk), .rst(rst), .byte_valid(byte_valid),
    .data_valid(data_valid), .done(done), .not_found(not_found)
);

// File: tb/sector_seek_ctrl_test.sv
module sector_seek_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0, three_revs = 1'b0;
    logic [7:0] req_track = '0, req_sector = '0;
    logic       byte_valid = 1'b0, sync_flag = 1'b0, index_pulse = 1'b0;
    logic [7:0] byte_in = '0;
    logic       data_valid, done, not_found;
    logic [7:0] data_out;

    int checks = 0, errors = 0, done_cnt = 0, nf_cnt = 0;
    logic [7:0] expq[$];

    always #10 clk = ~clk;

    sector_seek_ctrl uut (
        .clk(clk), .rst(rst), .start(start), .req_track(req_track),
        .req_sector(req_sector), .three_revs(three_revs),
        .byte_valid(byte_valid), .byte_in(byte_in), .sync_flag(sync_flag),
        .index_pulse(index_pulse), .data_valid(data_valid),
        .data_out(data_out), .done(done), .not_found(not_found)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (data_valid) begin
                checks++;
                if (expq.size() == 0) begin
                    errors++;
                    $display("FAIL R4: unexpected data byte actual %0h expected none", data_out);
                end else begin
                    logic [7:0] e;
                    e = expq.pop_front();
                    if (data_out !== e) begin
                        errors++;
                        $display("FAIL R4: data actual %0h expected %0h", data_out, e);
                    end
                end
            end
            if (done) done_cnt++;
            if (not_found) nf_cnt++;
        end
    end

    task automatic put(input logic [7:0] b, input logic s);
        @(negedge clk) byte_valid = 1'b1; byte_in = b; sync_flag = s;
        @(negedge clk) byte_valid = 1'b0; sync_flag = 1'b0;
    endtask

    task automatic gap(input int k);
        for (int i = 0; i < k; i++) put(8'h4E, 1'b0);
    endtask

    task automatic preamble(input int nsync);
        for (int i = 0; i < 4; i++) put(8'h00, 1'b0);
        for (int i = 0; i < nsync; i++) put(8'hA1, 1'b1);
    endtask

    task automatic header(input logic [7:0] trk, input logic [7:0] sec, input logic [7:0] n, input int nsync);
        preamble(nsync);
        put(8'hFE, 1'b0);
        put(trk, 1'b0); put(8'h00, 1'b0); put(sec, 1'b0); put(n, 1'b0);
        put(8'h12, 1'b0); put(8'h34, 1'b0);
        gap(6);
    endtask

    // the driver pushes the bytes it expects to see into the scoreboard queue
    task automatic data_field(input int n, input logic [7:0] seed, input bit expect_out);
        preamble(3);
        put(8'hFB, 1'b0);
        for (int i = 0; i < (128 << n); i++) begin
            logic [7:0] b;
            b = seed + 8'(i * 7);
            if (expect_out) expq.push_back(b);
            put(b, 1'b0);
        end
        gap(4);
    endtask

    task automatic command(input logic [7:0] trk, input logic [7:0] sec, input logic three);
        @(negedge clk) start = 1'b1; req_track = trk; req_sector = sec; three_revs = three;
        @(negedge clk) start = 1'b0; req_track = 8'hEE; req_sector = 8'hEE; three_revs = 1'b0;
    endtask

    task automatic idx(input int width);
        @(negedge clk) index_pulse = 1'b1;
        repeat (width) @(negedge clk);
        index_pulse = 1'b0;
    endtask

    task automatic settle;
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int d0, n0;
        repeat (4) @(negedge clk);
        // R10 reset state
        check(!data_valid && !done && !not_found, "R10 reset outputs", int'({data_valid, done, not_found}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!data_valid && !done && !not_found, "R10 after reset", int'({data_valid, done, not_found}), 0);

        // R4 R5 basic match, 128 bytes
        d0 = done_cnt; n0 = nf_cnt;
        command(8'd2, 8'd4, 1'b0);
        gap(5); header(8'd2, 8'd4, 8'd0, 3); data_field(0, 8'h10, 1); settle();
        check(done_cnt - d0 == 1, "R5 done once", done_cnt - d0, 1);
        check(expq.size() == 0, "R4 all bytes out", expq.size(), 0);
        check(nf_cnt == n0, "R6 no error on hit", nf_cnt - n0, 0);

        // R2 R3 unordered headers, wrong track, size code 1
        d0 = done_cnt;
        command(8'd2, 8'd9, 1'b0);
        header(8'd2, 8'd5, 8'd0, 3); data_field(0, 8'h70, 0);
        header(8'd7, 8'd9, 8'd0, 3); data_field(0, 8'h80, 0);
        header(8'd2, 8'd3, 8'd0, 3); data_field(0, 8'h90, 0);
        header(8'd2, 8'd9, 8'd1, 3); data_field(1, 8'h55, 1); settle();
        check(done_cnt - d0 == 1, "R2 done after matching header", done_cnt - d0, 1);
        check(expq.size() == 0, "R4 256 byte field", expq.size(), 0);

        // R3 duplicate: first wins, second ignored
        d0 = done_cnt;
        command(8'd2, 8'd4, 1'b0);
        header(8'd2, 8'd4, 8'd0, 3); data_field(0, 8'h20, 1);
        header(8'd2, 8'd4, 8'd0, 3); data_field(0, 8'hC0, 0); settle();
        check(done_cnt - d0 == 1, "R3 duplicate served once", done_cnt - d0, 1);
        check(expq.size() == 0, "R3 first duplicate data", expq.size(), 0);

        // R1 two sync bytes do not form a mark
        d0 = done_cnt;
        command(8'd3, 8'd1, 1'b0);
        header(8'd3, 8'd1, 8'd0, 2); data_field(0, 8'h33, 0);
        header(8'd3, 8'd1, 8'd0, 3); data_field(0, 8'h44, 1); settle();
        check(done_cnt - d0 == 1, "R1 short sync rejected", done_cnt - d0, 1);
        check(expq.size() == 0, "R1 data after full sync", expq.size(), 0);

        // R8 data mark window
        d0 = done_cnt;
        command(8'd4, 8'd2, 1'b0);
        header(8'd4, 8'd2, 8'd0, 3); gap(70); data_field(0, 8'h61, 0);
        header(8'd4, 8'd2, 8'd0, 3); gap(40); data_field(0, 8'h40, 1); settle();
        check(done_cnt - d0 == 1, "R8 late data mark dropped", done_cnt - d0, 1);
        check(expq.size() == 0, "R8 data within window", expq.size(), 0);

        // R6 default two revolutions
        d0 = done_cnt; n0 = nf_cnt;
        command(8'd9, 8'd9, 1'b0);
        header(8'd1, 8'd1, 8'd0, 3); idx(1); settle();
        check(nf_cnt == n0, "R6 no error after one edge", nf_cnt - n0, 0);
        header(8'd1, 8'd2, 8'd0, 3); idx(1); settle();
        check(nf_cnt - n0 == 1, "R6 error after two edges", nf_cnt - n0, 1);
        check(done_cnt == d0, "R6 no done on timeout", done_cnt - d0, 0);

        // R6 three revolutions
        n0 = nf_cnt;
        command(8'd9, 8'd9, 1'b1);
        idx(1); gap(3); idx(1); settle();
        check(nf_cnt == n0, "R6 three_revs no error at two", nf_cnt - n0, 0);
        idx(1); settle();
        check(nf_cnt - n0 == 1, "R6 three_revs error at three", nf_cnt - n0, 1);

        // R7 idle edges ignored, held level counts once, cleared on start
        d0 = done_cnt; n0 = nf_cnt;
        idx(1); gap(2); idx(1); gap(2); idx(1); settle();
        command(8'd5, 8'd5, 1'b0);
        idx(12); settle();
        check(nf_cnt == n0, "R7 one edge only", nf_cnt - n0, 0);
        header(8'd5, 8'd5, 8'd0, 3); data_field(0, 8'hA1, 1); settle();
        check(done_cnt - d0 == 1, "R7 search still alive", done_cnt - d0, 1);
        check(expq.size() == 0, "R7 data delivered", expq.size(), 0);

        // R9 start while busy is ignored
        d0 = done_cnt;
        command(8'd6, 8'd1, 1'b0);
        gap(3);
        command(8'd6, 8'd2, 1'b1);
        header(8'd6, 8'd2, 8'd0, 3); data_field(0, 8'h0F, 0);
        header(8'd6, 8'd1, 8'd0, 3); data_field(0, 8'hF0, 1); settle();
        check(done_cnt - d0 == 1, "R9 original request kept", done_cnt - d0, 1);
        check(expq.size() == 0, "R9 data of first request", expq.size(), 0);

        finish_run();
    end
endmodule